// File: doc/BRIEF.md
# Power-up configuration word loader

This block fetches one 16-bit configuration word after reset and then holds it unchanged until the next reset. A two-bit source selector is sampled in the first clock cycle after reset. It can pick one of three sources.

- A serial ROM. The block is the clock master here. It sends a fixed read command to the ROM and then shifts in sixteen data bits.
- An external host. The host toggles its own clock and presents one bit per rising edge.
- Three strap pins. These set the three capability bits. Every other bit, including the five-bit station address, is zero.

The loaded word is presented on `cfg_word_o` and qualified by `cfg_valid_o`. This output is a one-shot result stream with no ready input. It cannot be back-pressured. Once valid rises, the word and the flag stay constant, so a consumer can sample them at any later cycle. The serial clock pin is modelled as separate input, output and output-enable signals. The output-enable is high only when the ROM source is selected.

Word layout:

| Bits | Field |
|------|-------|
| 15..11 | station address |
| 10 | 10 Mb/s half-duplex capability |
| 9 | 10 Mb/s full-duplex capability |
| 8 | 100 Mb/s four-pair capability |
| 7 | isolate disable |
| 6 | repeater mode |
| 5..0 | spare |

Top module: `cfg_word_loader`

## Requirements
- R1: `mode_i` is decoded once, in the first clock cycle after `rst_n` rises: 2'b10 selects the ROM source, 2'b01 selects the host source and 2'b00 selects the strap source. A later change on `mode_i` does not alter the loaded word.
- R2: With the ROM source, `rom_clk_oe_o` is 1. `rom_sdo_o` presents the nine command bits 1, 1, 0, 0, 0, 0, 0, 0, 0 in that order, one per ROM clock rising edge. Each bit changes only while `rom_clk_o` is low.
- R3: Each high phase and each low phase of `rom_clk_o` between edges lasts exactly `HALF_CYC` system clock cycles.
- R4: The ROM data bit is sampled at the end of the high phase of rising edges 10 to 25. The first sampled bit lands in word bit 0 and the last in bit 15.
- R5: `cfg_valid_o` rises after the 25th ROM clock pulse ends. No further rising edge appears on `rom_clk_o` afterwards, and it stays low.
- R6: With the host source, `rom_clk_oe_o` is 0. `ser_data_i` is captured on each of the first 16 rising edges of `host_clk_i`, the first capture into bit 0. `cfg_valid_o` stays low until the 16th edge, and later edges have no effect on the word.
- R7: With the strap source, bits 10, 9 and 8 equal `strap_hd_i`, `strap_fd_i` and `strap_t4_i` as seen one cycle after reset. All other bits are 0, and `cfg_valid_o` is 1 no later than three clock cycles after reset release.
- R8: Once `cfg_valid_o` is 1, it and `cfg_word_o` hold their values until reset, whatever the strap, mode, host clock and data inputs do.
- R9: While `rst_n` is low, `cfg_word_o` is 0, `cfg_valid_o` is 0 and `rom_clk_o` is 0.
- R10: The unused selector code 2'b11 selects the strap source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| mode_i | input | 2 | Source selector: 10 ROM, 01 host, 00/11 straps |
| strap_hd_i | input | 1 | Strap for word bit 10 |
| strap_fd_i | input | 1 | Strap for word bit 9 |
| strap_t4_i | input | 1 | Strap for word bit 8 |
| rom_clk_o | output | 1 | Serial clock driven to the ROM |
| rom_clk_oe_o | output | 1 | Output enable of the serial clock pin |
| rom_sdo_o | output | 1 | Command stream to the ROM |
| host_clk_i | input | 1 | Serial clock from an external host |
| ser_data_i | input | 1 | Serial data from the ROM or the host |
| cfg_word_o | output | 16 | Loaded configuration word |
| cfg_valid_o | output | 1 | Word valid; stays high once set |

## Verification
The bench builds the block with `HALF_CYC` = 5 and `SYNC_STAGES` = 2. A whole ROM read then takes about 250 cycles instead of several thousand. This leaves room to repeat reset many times: two ROM words, including a lone low-end bit that shows the order reversal, a host load with trailing edges, and both strap codes. The ROM clock phase lengths are still compared against `HALF_CYC` exactly. The host clock is toggled at eight system cycles per phase, so both synchronizer stages are exercised.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam int WORD_W   = 16;
  localparam int CMD_W    = 9;
  localparam logic [CMD_W-1:0] ROM_CMD = 9'b1_10_000000;

  localparam int POS_HD   = 10;
  localparam int POS_FD   = 9;
  localparam int POS_T4   = 8;

  typedef enum logic [1:0] {
    SRC_STRAP = 2'b00,
    SRC_HOST  = 2'b01,
    SRC_ROM   = 2'b10
  } src_mode_t;

  typedef enum logic [1:0] {
    LD_LATCH = 2'b00,
    LD_RUN   = 2'b01,
    LD_HOLD  = 2'b10
  } ld_state_t;

  function automatic src_mode_t decode_mode(input logic [1:0] raw);
    case (raw)
      2'b10:   return SRC_ROM;
      2'b01:   return SRC_HOST;
      default: return SRC_STRAP;
    endcase
  endfunction

  function automatic logic cmd_bit(input int idx);
    if (idx < CMD_W) return ROM_CMD[CMD_W-1-idx];
    return 1'b0;
  endfunction

endpackage

// File: rtl/cfg_rom_reader.sv
module cfg_rom_reader
  import cfg_loader_pkg::*;
#(
  parameter int HALF_CYC = 113
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rom_sdi_i,
  output logic              rom_clk_o,
  output logic              rom_sdo_o,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);

  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BITS  = CMD_W + WORD_W;
  localparam int IDX_W = $clog2(BITS + 1);

  logic              busy_q;
  logic              sck_q;
  logic              sdo_q;
  logic              done_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] sh_q;
  logic              phase_end;

  assign phase_end = (cnt_q == CNT_W'(HALF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      sdo_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else if (start_i && !busy_q && !done_q) begin
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      sdo_q  <= cmd_bit(0);
    end else if (busy_q) begin
      if (!phase_end) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
        end else begin
          sck_q <= 1'b0;
          if (idx_q >= IDX_W'(CMD_W))
            sh_q <= {rom_sdi_i, sh_q[WORD_W-1:1]};
          if (idx_q == IDX_W'(BITS - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            sdo_q  <= 1'b0;
          end else begin
            idx_q <= idx_q + 1'b1;
            sdo_q <= cmd_bit(int'(idx_q) + 1);
          end
        end
      end
    end
  end

  assign rom_clk_o = sck_q;
  assign rom_sdo_o = sdo_q;
  assign word_o    = sh_q;
  assign done_o    = done_q;

endmodule

// File: rtl/cfg_host_capture.sv
module cfg_host_capture
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              host_clk_i,
  input  logic              host_dat_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [SYNC_STAGES-1:0] clk_sync;
  logic [SYNC_STAGES-1:0] dat_sync;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            clk_sync[0] <= 1'b0;
            dat_sync[0] <= 1'b0;
          end else begin
            clk_sync[0] <= host_clk_i;
            dat_sync[0] <= host_dat_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            clk_sync[g] <= 1'b0;
            dat_sync[g] <= 1'b0;
          end else begin
            clk_sync[g] <= clk_sync[g-1];
            dat_sync[g] <= dat_sync[g-1];
          end
        end
      end
    end
  endgenerate

  logic              clk_prev_q;
  logic              rise;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;

  assign rise = clk_sync[SYNC_STAGES-1] && !clk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b0;
      cnt_q      <= '0;
      sh_q       <= '0;
    end else begin
      clk_prev_q <= clk_sync[SYNC_STAGES-1];
      if (arm_i && rise && (cnt_q < CNT_W'(WORD_W))) begin
        sh_q  <= {dat_sync[SYNC_STAGES-1], sh_q[WORD_W-1:1]};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign word_o = sh_q;
  assign done_o = (cnt_q == CNT_W'(WORD_W));

endmodule

// File: rtl/cfg_strap_builder.sv
module cfg_strap_builder
  import cfg_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              hd_i,
  input  logic              fd_i,
  input  logic              t4_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);

  logic [WORD_W-1:0] word_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      done_q <= 1'b0;
    end else if (start_i && !done_q) begin
      word_q         <= '0;
      word_q[POS_HD] <= hd_i;
      word_q[POS_FD] <= fd_i;
      word_q[POS_T4] <= t4_i;
      done_q         <= 1'b1;
    end
  end

  assign word_o = word_q;
  assign done_o = done_q;

endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader
  import cfg_loader_pkg::*;
#(
  parameter int HALF_CYC    = 113,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_i,
  input  logic        strap_hd_i,
  input  logic        strap_fd_i,
  input  logic        strap_t4_i,
  output logic        rom_clk_o,
  output logic        rom_clk_oe_o,
  output logic        rom_sdo_o,
  input  logic        host_clk_i,
  input  logic        ser_data_i,
  output logic [15:0] cfg_word_o,
  output logic        cfg_valid_o
);

  src_mode_t         mode_q;
  ld_state_t         st_q;
  logic              start_q;
  logic [WORD_W-1:0] cfg_q;
  logic              valid_q;

  logic [WORD_W-1:0] rom_word, host_word, strap_word, sel_word;
  logic              rom_done, host_done, strap_done, sel_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= SRC_STRAP;
      st_q    <= LD_LATCH;
      start_q <= 1'b0;
      cfg_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (st_q)
        LD_LATCH: begin
          mode_q  <= decode_mode(mode_i);
          start_q <= 1'b1;
          st_q    <= LD_RUN;
        end
        LD_RUN: begin
          if (sel_done) begin
            cfg_q   <= sel_word;
            valid_q <= 1'b1;
            st_q    <= LD_HOLD;
          end
        end
        default: st_q <= LD_HOLD;
      endcase
    end
  end

  cfg_rom_reader #(
    .HALF_CYC (HALF_CYC)
  ) u_rom (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_q && (mode_q == SRC_ROM)),
    .rom_sdi_i (ser_data_i),
    .rom_clk_o (rom_clk_o),
    .rom_sdo_o (rom_sdo_o),
    .word_o    (rom_word),
    .done_o    (rom_done)
  );

  cfg_host_capture #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      ((st_q == LD_RUN) && (mode_q == SRC_HOST)),
    .host_clk_i (host_clk_i),
    .host_dat_i (ser_data_i),
    .word_o     (host_word),
    .done_o     (host_done)
  );

  cfg_strap_builder u_strap (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_q && (mode_q == SRC_STRAP)),
    .hd_i    (strap_hd_i),
    .fd_i    (strap_fd_i),
    .t4_i    (strap_t4_i),
    .word_o  (strap_word),
    .done_o  (strap_done)
  );

  always_comb begin
    case (mode_q)
      SRC_ROM:  begin sel_word = rom_word;   sel_done = rom_done;   end
      SRC_HOST: begin sel_word = host_word;  sel_done = host_done;  end
      default:  begin sel_word = strap_word; sel_done = strap_done; end
    endcase
  end

  assign rom_clk_oe_o = (mode_q == SRC_ROM);
  assign cfg_word_o   = cfg_q;
  assign cfg_valid_o  = valid_q;

endmodule

// File: rtl/cfg_word_loader_chk.sv
module cfg_word_loader_chk
  import cfg_loader_pkg::*;
#(
  parameter int HALF_CYC = 113
) (
  input logic        clk,
  input logic        rst_n,
  input src_mode_t   mode_q,
  input logic        rom_clk_o,
  input logic        rom_clk_oe_o,
  input logic [15:0] cfg_word_o,
  input logic        cfg_valid_o
);

  localparam int HL_W = $clog2(HALF_CYC + 2) + 1;
  logic [HL_W-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_len <= '0;
    else        hi_len <= rom_clk_o ? hi_len + 1'b1 : '0;
  end

  // R8
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid_o |=> cfg_valid_o);

  // R8
  word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid_o |=> $stable(cfg_word_o));

  // R5
  clk_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid_o |-> !rom_clk_o);

  // R6
  no_drive_when_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_clk_oe_o |-> !rom_clk_o);

  // R3
  high_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_clk_o) |-> (hi_len == HL_W'(HALF_CYC)));

  // R7
  strap_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid_o && (mode_q == SRC_STRAP)) |->
      ((cfg_word_o[15:11] == 5'd0) && (cfg_word_o[7:0] == 8'd0)));

endmodule

bind cfg_word_loader cfg_word_loader_chk #(
  .HALF_CYC (HALF_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_q       (mode_q),
  .rom_clk_o    (rom_clk_o),
  .rom_clk_oe_o (rom_clk_oe_o),
  .cfg_word_o   (cfg_word_o),
  .cfg_valid_o  (cfg_valid_o)
);

// File: tb/cfg_word_loader_tb.sv
`timescale 1ns/1ps
module cfg_word_loader_tb;

  localparam int HALF = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b10;
  logic        hd = 1'b0, fd = 1'b0, t4 = 1'b0;
  logic        host_clk = 1'b0, host_dat = 1'b0;
  logic        rom_sdi;
  logic        rom_clk, rom_oe, rom_sdo;
  logic [15:0] word;
  logic        valid;
  logic        use_host = 1'b0;

  always #4 clk = ~clk;

  cfg_word_loader #(.HALF_CYC(HALF), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .strap_hd_i(hd), .strap_fd_i(fd), .strap_t4_i(t4),
    .rom_clk_o(rom_clk), .rom_clk_oe_o(rom_oe), .rom_sdo_o(rom_sdo),
    .host_clk_i(host_clk), .ser_data_i(use_host ? host_dat : rom_sdi),
    .cfg_word_o(word), .cfg_valid_o(valid)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ROM behavioural model: command bits clocked in on edges 1..9, data out after edges 10..25
  logic [15:0] mem = 16'h0;
  int          edges;
  logic [8:0]  cmd_seen;
  always @(posedge rom_clk or negedge rst_n) begin
    if (!rst_n) begin
      edges <= 0; cmd_seen <= '0; rom_sdi <= 1'b0;
    end else begin
      edges <= edges + 1;
      if (edges < 9) cmd_seen <= {cmd_seen[7:0], rom_sdo};
      if (edges >= 9 && edges < 25) rom_sdi <= mem[15-(edges-9)];
    end
  end

  int hi_total, lo_total;
  always @(negedge clk) begin
    if (!rst_n) begin hi_total = 0; lo_total = 0; end
    else if (rom_clk) hi_total++;
    else if (edges >= 1 && edges <= 24) lo_total++;
  end

  // scoreboard
  logic [15:0] exp_q[$];
  string       req_q[$];
  always begin
    @(posedge valid);
    @(negedge clk);
    if (exp_q.size() == 0) chk(1'b0, "R8 unexpected load", {16'h0, word}, 32'h0);
    else begin
      logic [15:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(word == e, r, {16'h0, word}, {16'h0, e});
    end
  end

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  task automatic start_run(input logic [1:0] m, input logic [15:0] e, input string r);
    @(negedge clk);
    rst_n = 1'b0;
    mode = m;
    repeat (3) @(negedge clk);
    chk(word == 16'h0 && !valid && !rom_clk, "R9 reset state", {15'h0, valid, word}, 32'h0);
    exp_q.push_back(e);
    req_q.push_back(r);
    rst_n = 1'b1;
  endtask

  task automatic wait_valid();
    while (!valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic host_edge(input logic b);
    host_dat = b;
    repeat (8) @(negedge clk);
    host_clk = 1'b1;
    repeat (8) @(negedge clk);
    host_clk = 1'b0;
  endtask

  task automatic rom_case(input logic [15:0] m);
    use_host = 1'b0;
    mem = m;
    start_run(2'b10, rev16(m), "R4 ROM word LSB-first");
    @(negedge clk); @(negedge clk);
    chk(rom_oe == 1'b1, "R2 clock driven", {31'h0, rom_oe}, 32'h1);
    wait_valid();
    chk(cmd_seen == 9'b110000000, "R2 command bits", {23'h0, cmd_seen}, 32'h180);
    chk(edges == 25, "R5 edge count", edges, 25);
    chk(hi_total == 25*HALF, "R3 high phases", hi_total, 25*HALF);
    chk(lo_total == 24*HALF, "R3 low phases", lo_total, 24*HALF);
    repeat (60) @(negedge clk);
    chk(edges == 25 && !rom_clk, "R5 clock parked low", edges, 25);
  endtask

  initial begin
    rom_case(16'hA5C3);
    begin
      logic [15:0] held;
      held = word;
      mode = 2'b00; hd = 1'b1; fd = 1'b1; t4 = 1'b1;
      repeat (20) @(negedge clk);
      chk(word == held && valid, "R1 mode change ignored", {16'h0, word}, {16'h0, held});
    end
    rom_case(16'h0001);

    // host source
    use_host = 1'b1;
    start_run(2'b01, 16'h3C96, "R6 host word");
    @(negedge clk); @(negedge clk);
    chk(rom_oe == 1'b0, "R6 clock is input", {31'h0, rom_oe}, 32'h0);
    for (int i = 0; i < 15; i++) host_edge(1'((16'h3C96 >> i) & 1));
    repeat (6) @(negedge clk);
    chk(valid == 1'b0, "R6 not done after 15 edges", {31'h0, valid}, 32'h0);
    host_edge(1'b0);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 4; i++) host_edge(1'b1);
    repeat (6) @(negedge clk);
    chk(word == 16'h3C96, "R6 later edges ignored", {16'h0, word}, 32'h3C96);

    // strap source
    use_host = 1'b0;
    hd = 1'b1; fd = 1'b0; t4 = 1'b1;
    start_run(2'b00, 16'h0500, "R7 strap word");
    begin
      int n;
      n = 0;
      while (!valid && n < 10) begin @(negedge clk); n++; end
      chk(n <= 3, "R7 strap latency", n, 3);
    end
    @(negedge clk);
    hd = 1'b0; fd = 1'b1; t4 = 1'b0;
    repeat (10) @(negedge clk);
    chk(word == 16'h0500, "R8 straps ignored after load", {16'h0, word}, 32'h0500);

    start_run(2'b11, 16'h0200, "R10 code 11 uses straps");
    wait_valid();
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all loads seen", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule